// File: doc/BRIEF.md
# Bounded Grant Latency Monitor

This block is a synchronous observer placed beside a bus arbiter. It watches the request and grant lines and checks one latency promise. When master A asks for the bus while the bus is idle, A must receive a grant within a short window. The promise is waived if master B or master C also asks during that window. A broken promise produces a one-cycle violation pulse and sets an error flag that stays set.

An obligation can open on any cycle, so several can be outstanding at once. The monitor keeps each open obligation as one bit of an age vector, indexed by the number of cycles since it opened.

The window length is a parameter. `WIN_STEPS` counts the cycles that follow the opening cycle, so the window spans `WIN_STEPS + 1` clock cycles in total. The default is 4 steps, which gives five cycles.

Top module: `grant_latency_mon`

## Requirements
- R1: An obligation opens only in a cycle where `a_req` and `bus_free` are both 1. Either signal alone opens nothing.
- R2: An obligation opened in cycle t covers cycles t through t+WIN_STEPS, which is five cycles at the default of 4. A grant in cycle t+WIN_STEPS+1 or later does not discharge it.
- R3: A 1 on `b_req` or `c_req` in any cycle of the window cancels the obligation. This includes the opening cycle and the last cycle.
- R4: A 1 on `a_grant` in any cycle of the window discharges the obligation. This includes the opening cycle and the last cycle.
- R5: An obligation opened in cycle t and neither cancelled nor discharged raises `viol_o`. The pulse is one clock cycle long and appears in cycle t+WIN_STEPS+1, so it is visible just after the clock edge that ends cycle t+WIN_STEPS.
- R6: Obligations that overlap are tracked independently. Each of k consecutive unanswered opening cycles gives its own `viol_o` pulse, and the k pulses fall on k consecutive cycles.
- R7: `err_o` becomes 1 together with the first `viol_o` pulse. It then stays 1 until reset.
- R8: While `rst_n` is 0, all pending obligations are discarded and `viol_o` and `err_o` are held at 0. An obligation opened before reset never produces a pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset. It asserts asynchronously and is released synchronously. |
| a_req | input | 1 | Request from master A |
| bus_free | input | 1 | The bus is idle |
| b_req | input | 1 | Competing request from master B |
| c_req | input | 1 | Competing request from master C |
| a_grant | input | 1 | Grant to master A |
| viol_o | output | 1 | One-cycle pulse when an obligation expires unanswered |
| err_o | output | 1 | Sticky error flag |

## Verification
The hardest case to reach is a run of overlapping obligations that all expire unanswered. This needs opening cycles with no grant and no competing request on any of the following window cycles. Uniform random inputs almost never produce it.

The stimulus therefore opens obligations on several consecutive cycles and then keeps every response line quiet. The random phase drives each response line only rarely, so long quiet stretches with stacked obligations occur often.

The boundary cycles are driven by directed cases:
- a grant or a competing request on the opening cycle;
- a grant or a competing request on the last window cycle;
- a grant one cycle after the window has closed;
- a reset that lands while obligations are pending.

// File: rtl/glm_pkg.sv
package glm_pkg;
  typedef struct packed {
    logic open;   // new obligation this cycle
    logic answer; // grant or competing request this cycle
  } glm_evt_t;
endpackage

// File: rtl/glm_evt_decode.sv
module glm_evt_decode
  import glm_pkg::*;
(
  input  logic     a_req,
  input  logic     bus_free,
  input  logic     b_req,
  input  logic     c_req,
  input  logic     a_grant,
  output glm_evt_t evt_o
);
  always_comb begin
    evt_o.open   = a_req & bus_free;
    evt_o.answer = a_grant | b_req | c_req;
  end
endmodule

// File: rtl/glm_age_track.sv
module glm_age_track
  import glm_pkg::*;
#(
  parameter int WIN_STEPS = 4
) (
  input  logic     clk,
  input  logic     rst_n,
  input  glm_evt_t evt_i,
  output logic     expire_o
);
  localparam int LAST = WIN_STEPS - 1;

  logic [LAST:0] age_q, age_d;
  logic          expire_q, expire_d;
  logic          upd_en;

  // Next-state: an answer this cycle empties every stage; survivors age one step.
  always_comb begin
    age_d[0] = evt_i.open & ~evt_i.answer;
    expire_d = age_q[LAST] & ~evt_i.answer;
  end

  generate
    for (genvar i = 1; i <= LAST; i++) begin : g_stage
      always_comb age_d[i] = age_q[i-1] & ~evt_i.answer;
    end
  endgenerate

  assign upd_en = evt_i.open | (|age_q) | expire_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      age_q    <= '0;
      expire_q <= 1'b0;
    end else if (upd_en) begin
      age_q    <= age_d;
      expire_q <= expire_d;
    end
  end

  assign expire_o = expire_q;

  // R3 / R4: any answer leaves no obligation pending afterwards
  a_r3_r4_answer_flushes: assert property (@(posedge clk) disable iff (!rst_n)
    evt_i.answer |=> (age_q == '0));

  // R1: with nothing pending and no opening, nothing becomes pending
  a_r1_no_spurious_open: assert property (@(posedge clk) disable iff (!rst_n)
    (!evt_i.open && age_q == '0) |=> (age_q == '0));
endmodule

// File: rtl/glm_sticky.sv
module glm_sticky (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  output logic flag_o
);
  logic flag_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     flag_q <= 1'b0;
    else if (set_i) flag_q <= 1'b1;
  end

  assign flag_o = flag_q | set_i;

  // R7: once raised the flag never drops outside reset
  a_r7_flag_holds: assert property (@(posedge clk) disable iff (!rst_n)
    flag_o |=> flag_o);
endmodule

// File: rtl/grant_latency_mon.sv
module grant_latency_mon
  import glm_pkg::*;
#(
  parameter int WIN_STEPS = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic a_req,
  input  logic bus_free,
  input  logic b_req,
  input  logic c_req,
  input  logic a_grant,
  output logic viol_o,
  output logic err_o
);
  glm_evt_t evt;
  logic     expire;

  glm_evt_decode u_dec (
    .a_req   (a_req),
    .bus_free(bus_free),
    .b_req   (b_req),
    .c_req   (c_req),
    .a_grant (a_grant),
    .evt_o   (evt)
  );

  glm_age_track #(.WIN_STEPS(WIN_STEPS)) u_track (
    .clk     (clk),
    .rst_n   (rst_n),
    .evt_i   (evt),
    .expire_o(expire)
  );

  glm_sticky u_err (
    .clk   (clk),
    .rst_n (rst_n),
    .set_i (expire),
    .flag_o(err_o)
  );

  assign viol_o = expire;

  // R5: a pulse requires the previous cycle to be free of grants and competing requests
  a_r5_viol_after_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    viol_o |-> $past(!a_grant && !b_req && !c_req));

  // R7: every violation pulse is reflected in the error flag
  a_r7_viol_sets_err: assert property (@(posedge clk) disable iff (!rst_n)
    viol_o |-> err_o);
endmodule

// File: tb/grant_latency_mon_tb.sv
module grant_latency_mon_tb;
  localparam int WIN  = 4;
  localparam int HMAX = 8192;

  logic clk, rst_n;
  logic a_req, bus_free, b_req, c_req, a_grant;
  logic viol_o, err_o;

  int n_chk, n_bad;
  int cyc, base;
  logic exp_err;
  bit open_h [HMAX];
  bit ans_h  [HMAX];

  grant_latency_mon #(.WIN_STEPS(WIN)) u_dut (
    .clk(clk), .rst_n(rst_n), .a_req(a_req), .bus_free(bus_free),
    .b_req(b_req), .c_req(c_req), .a_grant(a_grant),
    .viol_o(viol_o), .err_o(err_o)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  function automatic logic exp_viol(input int c);
    if (c - WIN < base) return 1'b0;
    if (!open_h[c-WIN]) return 1'b0;
    for (int k = c - WIN; k <= c; k++)
      if (ans_h[k]) return 1'b0;
    return 1'b1;
  endfunction

  task automatic check(input logic act, input logic exp, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s cycle %0d: actual %b expected %b", tag, cyc, act, exp);
    end
  endtask

  task automatic step(input logic ar, bf, br, cr, ag, input string tag);
    logic ev;
    @(negedge clk);
    a_req = ar; bus_free = bf; b_req = br; c_req = cr; a_grant = ag;
    open_h[cyc] = ar & bf;
    ans_h[cyc]  = ag | br | cr;
    @(posedge clk);
    #1;
    ev = exp_viol(cyc);
    exp_err = exp_err | ev;
    check(viol_o, ev, {tag, " viol"});
    check(err_o, exp_err, "R7 err");
    cyc++;
  endtask

  task automatic idle(input int n, input string tag);
    for (int i = 0; i < n; i++) step(0, 0, 0, 0, 0, tag);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    a_req = 0; bus_free = 0; b_req = 0; c_req = 0; a_grant = 0;
    repeat (2) @(posedge clk);
    #1;
    check(viol_o, 1'b0, "R8 viol in reset");
    check(err_o, 1'b0, "R8 err in reset");
    @(negedge clk);
    rst_n = 1'b1;
    base = cyc;
    exp_err = 1'b0;
  endtask

  initial begin
    n_chk = 0; n_bad = 0; cyc = 0; base = 0; exp_err = 1'b0;
    a_req = 0; bus_free = 0; b_req = 0; c_req = 0; a_grant = 0;
    rst_n = 1'b0;
    void'($urandom(32'd20240611));
    do_reset();

    // R1: a half condition opens nothing
    step(1, 0, 0, 0, 0, "R1");
    step(0, 1, 0, 0, 0, "R1");
    idle(6, "R1");

    // R5 / R2: unanswered obligation pulses after the fifth cycle
    step(1, 1, 0, 0, 0, "R5");
    idle(6, "R5");

    // R4: grant on the last window cycle discharges
    step(1, 1, 0, 0, 0, "R4");
    idle(3, "R4");
    step(0, 0, 0, 0, 1, "R4");
    idle(3, "R4");

    // R4: grant on the opening cycle discharges
    step(1, 1, 0, 0, 1, "R4");
    idle(6, "R4");

    // R2: grant just after the window is too late
    step(1, 1, 0, 0, 0, "R2");
    idle(4, "R2");
    step(0, 0, 0, 0, 1, "R2");
    idle(2, "R2");

    // R3: competing request on the opening cycle, then on the last cycle
    step(1, 1, 1, 0, 0, "R3");
    idle(6, "R3");
    step(1, 1, 0, 0, 0, "R3");
    idle(3, "R3");
    step(0, 0, 0, 1, 0, "R3");
    idle(3, "R3");

    // R6: three consecutive openings give three pulses
    step(1, 1, 0, 0, 0, "R6");
    step(1, 1, 0, 0, 0, "R6");
    step(1, 1, 0, 0, 0, "R6");
    idle(8, "R6");

    // R8: reset with obligations pending discards them
    step(1, 1, 0, 0, 0, "R8");
    step(1, 1, 0, 0, 0, "R8");
    do_reset();
    idle(8, "R8");

    // random phase: rare answers so overlapping obligations expire
    for (int i = 0; i < 4000; i++) begin
      step(($urandom % 2) == 0, ($urandom % 3) != 0,
           ($urandom % 24) == 0, ($urandom % 24) == 0,
           ($urandom % 12) == 0, "R6 random");
      if (i == 2000) do_reset();
    end
    idle(6, "R5");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(20 * 200000);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule